// File: doc/BRIEF.md
# Battery-Backed SRAM Supervisor Control Core

This block is the digital control core that sits between a system bus and a bank of low-power SRAMs kept alive by a battery. It takes two digital flags from analog comparators: one shows that the main supply has dropped below the deselect threshold, the other shows that the battery is weak. It also takes the system chip enable and a two-bit bank select. It drives one active-low chip enable per SRAM bank, an active-low system reset and a latched battery-low flag.

The chip-enable path is combinational. The bank select picks one output, and that output follows the incoming enable. All outputs are forced high as soon as the supply flag shows a failure, which write-protects the memories. The reset output is held low during a supply failure and for a programmable recovery period after it. The battery flag is updated only when a check runs. A check runs on the clock edge that releases reset after every power-up. Further checks repeat at a programmable interval for as long as the supply stays good.

Top module: `nvram_supervisor`

## Requirements
- R1: With `ce_n` = 0 and `pwr_fail` = 0, `ce_out_n[sel]` is 0 and every other bit of `ce_out_n` is 1 in the same cycle (bit i belongs to `sel` = i).
- R2: With `ce_n` = 1, all bits of `ce_out_n` are 1.
- R3: With `pwr_fail` = 1, all bits of `ce_out_n` are 1 whatever `ce_n` and `sel` are.
- R4: `rst_out_n` is 0 whenever `rst` or `pwr_fail` is 1, and it falls in the same cycle that `pwr_fail` rises.
- R5: After a reset or a supply failure, `rst_out_n` rises on the T_REC-th consecutive rising edge at which `pwr_fail` is sampled 0. A single edge with `pwr_fail` = 1 restarts this count.
- R6: On the edge that raises `rst_out_n`, `batt_low` takes the value of `batt_low_cmp` (1 = battery weak). This is the power-up check.
- R7: While `pwr_fail` stays 0 after release, `batt_low` loads `batt_low_cmp` every T_CHK edges, counted from the release edge.
- R8: `batt_low_cmp` is ignored on all other edges, including the whole time that reset is held.
- R9: Once set, `batt_low` stays 1 through supply failures and between checks. It clears only when a later periodic check or power-up check samples `batt_low_cmp` = 0.
- R10: A synchronous `rst` drives `rst_out_n` = 0 and `batt_low` = 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail | input | 1 | 1 = supply below deselect threshold |
| batt_low_cmp | input | 1 | 1 = battery comparator reports weak battery |
| ce_n | input | 1 | Active-low system chip enable |
| sel | input | SEL_W (2) | Bank select |
| ce_out_n | output | NUM_CE (4) | Active-low per-bank chip enables |
| rst_out_n | output | 1 | Active-low system reset |
| batt_low | output | 1 | Latched battery-low flag |

## Verification
The chip-enable outputs respond combinationally, so the bench changes `ce_n`, `sel` or `pwr_fail` and samples one time step later, with no clock edge in between. Reset release and the battery checks are registered. The bench counts edges from the first edge that samples good supply: `rst_out_n` and the power-up value of `batt_low` must appear just after edge T_REC. Each periodic update must appear just after edge T_CHK counted from release. The bench drives its inputs one time unit after each rising edge and samples there. At every edge before a check, the comparator input is toggled and `batt_low` is checked to confirm that it has not moved.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        PWR_HOLD    = 2'd0,
        PWR_RECOVER = 2'd1,
        PWR_RUN     = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic running;        // reset released, supply good at last edge
        logic release_pulse;  // this edge moves the timer into RUN
    } por_status_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/nvs_ce_decoder.sv
module nvs_ce_decoder #(
    parameter int NUM_CE = 4,
    localparam int SEL_W = (NUM_CE < 2) ? 1 : $clog2(NUM_CE)
) (
    input  logic              ce_n,
    input  logic              pwr_fail,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CE-1:0] ce_out_n
);
    logic enable;
    assign enable = ~ce_n & ~pwr_fail;

    for (genvar i = 0; i < NUM_CE; i++) begin : g_bank
        assign ce_out_n[i] = ~(enable & (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/nvs_reset_timer.sv
module nvs_reset_timer
    import nvs_pkg::*;
#(
    parameter int unsigned T_REC = 200000,
    localparam int unsigned CW = cnt_width(T_REC)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_fail,
    output por_status_t status,
    output logic        rst_out_n
);
    pwr_state_e    state;
    logic [CW-1:0] cnt;
    logic          release_evt;

    assign release_evt = (state != PWR_RUN) && !pwr_fail && (cnt == CW'(T_REC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_HOLD;
            cnt   <= '0;
        end else if (pwr_fail) begin
            state <= PWR_HOLD;
            cnt   <= '0;
        end else begin
            case (state)
                PWR_RUN: state <= PWR_RUN;
                default: begin
                    if (release_evt) begin
                        state <= PWR_RUN;
                        cnt   <= '0;
                    end else begin
                        state <= PWR_RECOVER;
                        cnt   <= cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    assign status.running       = (state == PWR_RUN);
    assign status.release_pulse = release_evt;
    assign rst_out_n            = status.running & ~pwr_fail & ~rst;
endmodule

// File: rtl/nvs_batt_monitor.sv
module nvs_batt_monitor
    import nvs_pkg::*;
#(
    parameter int unsigned T_CHK = 32'd1_000_000_000,
    localparam int unsigned CW = cnt_width(T_CHK)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_fail,
    input  logic        batt_low_cmp,
    input  por_status_t status,
    output logic        batt_low
);
    logic [CW-1:0] ivl;
    logic          periodic;
    logic          check_now;

    assign periodic  = status.running && !pwr_fail && (ivl == CW'(T_CHK - 1));
    assign check_now = status.release_pulse | periodic;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl      <= '0;
            batt_low <= 1'b0;
        end else begin
            if (!status.running || pwr_fail || periodic) ivl <= '0;
            else                                         ivl <= ivl + CW'(1);
            if (check_now) batt_low <= batt_low_cmp;
        end
    end
endmodule

// File: rtl/nvram_supervisor.sv
module nvram_supervisor
    import nvs_pkg::*;
#(
    parameter int          NUM_CE = 4,
    parameter int unsigned T_REC  = 200000,
    parameter int unsigned T_CHK  = 32'd1_000_000_000,
    localparam int SEL_W = (NUM_CE < 2) ? 1 : $clog2(NUM_CE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_fail,
    input  logic              batt_low_cmp,
    input  logic              ce_n,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CE-1:0] ce_out_n,
    output logic              rst_out_n,
    output logic              batt_low
);
    por_status_t por;

    nvs_ce_decoder #(.NUM_CE(NUM_CE)) u_dec (
        .ce_n     (ce_n),
        .pwr_fail (pwr_fail),
        .sel      (sel),
        .ce_out_n (ce_out_n)
    );

    nvs_reset_timer #(.T_REC(T_REC)) u_por (
        .clk       (clk),
        .rst       (rst),
        .pwr_fail  (pwr_fail),
        .status    (por),
        .rst_out_n (rst_out_n)
    );

    nvs_batt_monitor #(.T_CHK(T_CHK)) u_batt (
        .clk          (clk),
        .rst          (rst),
        .pwr_fail     (pwr_fail),
        .batt_low_cmp (batt_low_cmp),
        .status       (por),
        .batt_low     (batt_low)
    );
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int NUM_CE = 4,
    localparam int SEL_W = (NUM_CE < 2) ? 1 : $clog2(NUM_CE)
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_fail,
    input logic              batt_low_cmp,
    input logic              ce_n,
    input logic [SEL_W-1:0]  sel,
    input logic [NUM_CE-1:0] ce_out_n,
    input logic              rst_out_n,
    input logic              batt_low
);
    logic unused_ok;
    assign unused_ok = batt_low_cmp ^ (|sel);

    assert_one_bank_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_out_n));

    assert_idle_enable_R2: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (&ce_out_n));

    assert_write_protect_R3: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |-> (&ce_out_n));

    assert_reset_on_fail_R4: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |-> !rst_out_n);

    assert_release_after_good_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> !$past(pwr_fail));

    assert_flag_moves_on_good_supply_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(batt_low) |-> !$past(pwr_fail));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!rst_out_n && !batt_low));
endmodule

bind nvram_supervisor nvs_checker #(.NUM_CE(NUM_CE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_fail     (pwr_fail),
    .batt_low_cmp (batt_low_cmp),
    .ce_n         (ce_n),
    .sel          (sel),
    .ce_out_n     (ce_out_n),
    .rst_out_n    (rst_out_n),
    .batt_low     (batt_low)
);

// File: tb/tb_nvram_supervisor.sv
`timescale 1ns/1ps
module tb_nvram_supervisor;
    localparam int NCE  = 4;
    localparam int TREC = 5;
    localparam int TCHK = 12;

    logic clk = 1'b0;
    logic rst, pwr_fail, batt_low_cmp, ce_n;
    logic [1:0] sel;
    logic [NCE-1:0] ce_out_n;
    logic rst_out_n, batt_low;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    nvram_supervisor #(.NUM_CE(NCE), .T_REC(TREC), .T_CHK(TCHK)) dut (
        .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .batt_low_cmp(batt_low_cmp),
        .ce_n(ce_n), .sel(sel), .ce_out_n(ce_out_n),
        .rst_out_n(rst_out_n), .batt_low(batt_low)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [NCE-1:0] exp_ce(input logic cen, input logic pf, input logic [1:0] s);
        return (cen | pf) ? '1 : ~(NCE'(1) << s);
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(100000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1; pwr_fail = 1'b1; batt_low_cmp = 1'b1; ce_n = 1'b1; sel = 2'd0;
        step(); step(); step();
        check("R10 reset rst_out_n", rst_out_n, 0);
        check("R10 reset batt_low", batt_low, 0);
        rst = 1'b0;
        step();

        // supply failed: sweep every select and enable
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                sel = s[1:0]; ce_n = c[0];
                #1;
                check("R3 write protect", ce_out_n, {NCE{1'b1}});
                check("R4 reset during fail", rst_out_n, 0);
            end
        end

        // recovery with weak battery; comparator ignored before release
        pwr_fail = 1'b0;
        for (int k = 1; k <= TREC; k++) begin
            step();
            check("R5 release timing", rst_out_n, (k == TREC) ? 1 : 0);
            check("R6/R8 power-up check", batt_low, (k == TREC) ? 1 : 0);
        end

        // decoder sweep with good supply
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                sel = s[1:0]; ce_n = c[0];
                #1;
                check(c ? "R2 idle enable" : "R1 bank decode", ce_out_n, exp_ce(c[0], 1'b0, s[1:0]));
            end
        end

        // first periodic interval: toggling comparator ignored, then clears
        for (int n = 1; n <= TCHK; n++) begin
            batt_low_cmp = (n == TCHK) ? 1'b0 : n[0];
            step();
            check((n == TCHK) ? "R7 periodic clear" : "R8/R9 ignored between checks",
                  batt_low, (n == TCHK) ? 0 : 1);
        end

        // second interval: weak battery sets flag at the interval edge
        batt_low_cmp = 1'b1;
        for (int n = 1; n <= TCHK; n++) begin
            step();
            check("R7 periodic set", batt_low, (n == TCHK) ? 1 : 0);
        end

        // supply fails again with enable active
        ce_n = 1'b0; sel = 2'd2; pwr_fail = 1'b1;
        #1;
        check("R4 reset falls with fail", rst_out_n, 0);
        check("R3 protect on fail", ce_out_n, {NCE{1'b1}});
        for (int n = 0; n < 3; n++) begin
            batt_low_cmp = n[0];
            step();
            check("R9 flag held in fail", batt_low, 1);
        end

        // partial recovery interrupted by a one-edge fail
        pwr_fail = 1'b0;
        for (int n = 0; n < 3; n++) begin
            batt_low_cmp = 1'b0;
            step();
            check("R5 still holding", rst_out_n, 0);
            check("R8 ignored during hold", batt_low, 1);
        end
        pwr_fail = 1'b1;
        step();
        pwr_fail = 1'b0;
        for (int k = 1; k <= TREC; k++) begin
            batt_low_cmp = (k == TREC) ? 1'b0 : 1'b1;
            step();
            check("R5 restarted count", rst_out_n, (k == TREC) ? 1 : 0);
            check("R6/R9 power-up clears", batt_low, (k == TREC) ? 0 : 1);
        end
        #1;
        check("R1 decode after recovery", ce_out_n, exp_ce(1'b0, 1'b0, 2'd2));

        // synchronous reset while running
        batt_low_cmp = 1'b1;
        for (int n = 1; n <= TCHK; n++) step();
        check("R7 set before reset", batt_low, 1);
        rst = 1'b1;
        step();
        check("R10 reset clears flag", batt_low, 0);
        check("R10 reset drops rst_out_n", rst_out_n, 0);
        report();
    end
endmodule